// File: doc/BRIEF.md
# Signature-Checked Class Code Preload Controller

After reset this block fixes a device's 24-bit class code and serves a small configuration register window. It first reads a handful of bytes from an external non-volatile store through a byte-read request/acknowledge port. The low addresses of the serial memory are checked for a four-byte marker. If that fails, the top of the parallel memory's address space is checked for a three-byte marker. When a marker matches, the three bytes that follow it become the class code. When neither matches, a jumper input picks one of two fixed defaults.

Until the load finishes, every configuration access gets a retry answer and is otherwise dropped. After that, a command word with five writable enables, a fixed status half, a read-only revision byte, a capability pointer and a one-bit class-code write unlock are available. The block also gates the system-error output on a reported address parity error by two of the command enables.

Top module: `cfg_preload_ctrl`

## Requirements
- R1: From reset until `preload_done` rises, every configuration access is acknowledged one cycle later with `cfg_retry`=1, and a write made in that window changes no register. `preload_done` is 0 after reset. Once `preload_done` is 1 it stays 1, and `nvm_req` stays 0 from then on.
- R2: The first device probed is the serial memory (`nvm_dev`=0). Its marker is valid when address 0 reads AAh, 1 reads 55h, 2 reads AAh and 3 reads 55h. In that case the class code is {byte 6, byte 5, byte 4}, with byte 4 as the least significant, and no request is ever made with `nvm_dev`=1.
- R3: When the serial marker fails, the parallel memory (`nvm_dev`=1) is probed, with T being the all-ones address. Its marker is valid when T reads AAh, T-1 reads 55h and T-3 reads 55h. In that case the class code is {T-5, T-6, T-7}, with T-7 as the least significant.
- R4: When neither marker is valid, the class code is 010400h if `jumper_sel`=0 and 010185h if `jumper_sel`=1.
- R5: A read of dword index 02h returns the class code in bits [31:8] and 01h in bits [7:0].
- R6: A write to dword 02h changes class-code byte k (bits [8k+7:8k], k=1..3, with `cfg_be[k]` set) only while the unlock bit is 1. Otherwise the class code keeps its value, and bits [7:0] never change.
- R7: Dword index 10h bit 0 is the unlock bit. It is writable through `cfg_be[0]`, resets to 0, and all other bits of that dword read 0.
- R8: Dword index 01h bits [15:0] form the command word. Only bits 8, 6, 2, 1 and 0 are writable, and the rest read 0. Bits [31:16] read 0010h: bit 20 is 1, bit 21 is 0 and bits [19:10] are 0.
- R9: `serr_o` is 1 in the cycle after `addr_par_err` is sampled high only if command bits 8 and 6 are both 1. With bit 6 clear, a parity error never raises `serr_o`.
- R10: Dword index 0Dh reads 00000060h (the capability pointer). Unmapped indices read 0.
- R11: While `nvm_req` is 1 and `nvm_ack` is 0, the next cycle keeps `nvm_req` at 1 with `nvm_addr` and `nvm_dev` unchanged.
- R12: `cfg_ack` is 1 exactly in the cycle after a cycle with `cfg_req`=1, and `cfg_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jumper_sel | input | 1 | Picks the default class code |
| nvm_req | output | 1 | Byte read request to external memory |
| nvm_dev | output | 1 | 0 = serial memory, 1 = parallel memory |
| nvm_addr | output | ADDR_W | Byte address of the read |
| nvm_ack | input | 1 | Read data valid, one-cycle pulse |
| nvm_rdata | input | 8 | Read data |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw_addr | input | 6 | Dword index of the access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | Access answered |
| cfg_retry | output | 1 | Access refused, preload still running |
| cfg_rdata | output | 32 | Read data |
| addr_par_err | input | 1 | Address parity error detected |
| serr_o | output | 1 | System error indication |
| preload_done | output | 1 | Class code load finished |

## Verification
The paths that are hard to reach are the fallbacks: a serial marker that fails only on its last byte, and a parallel marker that matches two of its three bytes. Either one must send the sequencer onward without keeping partial results. The bench drives a memory model whose contents are set before each reset, so each fallback is forced on purpose, and it records whether the parallel device was ever addressed. The retry window is reached by issuing accesses right after reset, while the model's response latency keeps the load in progress.

// File: rtl/cfgpl_pkg.sv
package cfgpl_pkg;

   localparam int CC_W        = 24;
   localparam int CC_BYTES    = CC_W / 8;
   localparam int EE_SIG_LEN  = 4;
   localparam int FL_SIG_LEN  = 3;
   localparam int EE_CC_BASE  = 4;
   localparam int FL_CC_BELOW = 7;

   localparam logic [CC_W-1:0] CC_DFLT_J0 = 24'h010400;
   localparam logic [CC_W-1:0] CC_DFLT_J1 = 24'h010185;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_EE_SIG,
      PS_EE_CC,
      PS_FL_SIG,
      PS_FL_CC,
      PS_DONE
   } probe_st_t;

   function automatic logic [7:0] ee_mark(input logic [2:0] idx);
      return idx[0] ? 8'h55 : 8'hAA;
   endfunction

   function automatic logic [7:0] fl_mark(input logic [2:0] idx);
      return (idx == 3'd0) ? 8'hAA : 8'h55;
   endfunction

   function automatic logic [2:0] fl_mark_off(input logic [2:0] idx);
      return (idx == 3'd2) ? 3'd3 : idx;
   endfunction

endpackage

// File: rtl/cfgpl_probe.sv
module cfgpl_probe
   import cfgpl_pkg::*;
#(
   parameter int ADDR_W = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jumper_sel,
   output logic              nvm_req,
   output logic              nvm_dev,
   output logic [ADDR_W-1:0] nvm_addr,
   input  logic              nvm_ack,
   input  logic [7:0]        nvm_rdata,
   output logic              ld_vld,
   output logic [CC_W-1:0]   ld_val
);

   localparam logic [ADDR_W-1:0] FL_TOP     = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] FL_CC_BASE = FL_TOP - ADDR_W'(FL_CC_BELOW);
   localparam logic [ADDR_W-1:0] EE_CC_A    = ADDR_W'(EE_CC_BASE);

   probe_st_t       st_q;
   logic [2:0]      idx_q;
   logic [15:0]     ccbuf_q;
   logic [ADDR_W-1:0] idx_a;

   assign idx_a = ADDR_W'(idx_q);

   always_comb begin
      nvm_req  = 1'b0;
      nvm_dev  = 1'b0;
      nvm_addr = '0;
      case (st_q)
         PS_EE_SIG: begin
            nvm_req  = 1'b1;
            nvm_addr = idx_a;
         end
         PS_EE_CC: begin
            nvm_req  = 1'b1;
            nvm_addr = EE_CC_A + idx_a;
         end
         PS_FL_SIG: begin
            nvm_req  = 1'b1;
            nvm_dev  = 1'b1;
            nvm_addr = FL_TOP - ADDR_W'(fl_mark_off(idx_q));
         end
         PS_FL_CC: begin
            nvm_req  = 1'b1;
            nvm_dev  = 1'b1;
            nvm_addr = FL_CC_BASE + idx_a;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         idx_q   <= '0;
         ccbuf_q <= '0;
         ld_vld  <= 1'b0;
         ld_val  <= '0;
      end else begin
         ld_vld <= 1'b0;
         case (st_q)
            PS_IDLE: begin
               st_q  <= PS_EE_SIG;
               idx_q <= '0;
            end
            PS_EE_SIG: if (nvm_ack) begin
               if (nvm_rdata != ee_mark(idx_q)) begin
                  st_q  <= PS_FL_SIG;
                  idx_q <= '0;
               end else if (idx_q == 3'(EE_SIG_LEN - 1)) begin
                  st_q  <= PS_EE_CC;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + 3'd1;
               end
            end
            PS_FL_SIG: if (nvm_ack) begin
               if (nvm_rdata != fl_mark(idx_q)) begin
                  st_q   <= PS_DONE;
                  ld_vld <= 1'b1;
                  ld_val <= jumper_sel ? CC_DFLT_J1 : CC_DFLT_J0;
               end else if (idx_q == 3'(FL_SIG_LEN - 1)) begin
                  st_q  <= PS_FL_CC;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + 3'd1;
               end
            end
            PS_EE_CC, PS_FL_CC: if (nvm_ack) begin
               case (idx_q[1:0])
                  2'd0:    ccbuf_q[7:0]  <= nvm_rdata;
                  2'd1:    ccbuf_q[15:8] <= nvm_rdata;
                  default: ;
               endcase
               if (idx_q == 3'(CC_BYTES - 1)) begin
                  st_q   <= PS_DONE;
                  ld_vld <= 1'b1;
                  ld_val <= {nvm_rdata, ccbuf_q};
               end else begin
                  idx_q <= idx_q + 3'd1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cfgpl_regs.sv
module cfgpl_regs
   import cfgpl_pkg::*;
#(
   parameter logic [7:0]  REV_ID    = 8'h01,
   parameter logic [7:0]  CAP_PTR   = 8'h60,
   parameter logic [15:0] CMD_WMASK = 16'h0147,
   parameter bit          CAPS_LIST = 1'b1,
   parameter bit          CAP_66MHZ = 1'b0,
   parameter logic [5:0]  DW_CMD    = 6'h01,
   parameter logic [5:0]  DW_CLASS  = 6'h02,
   parameter logic [5:0]  DW_CAP    = 6'h0D,
   parameter logic [5:0]  DW_CFG    = 6'h10
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_req,
   input  logic            cfg_we,
   input  logic [5:0]      cfg_dw_addr,
   input  logic [3:0]      cfg_be,
   input  logic [31:0]     cfg_wdata,
   output logic            cfg_ack,
   output logic            cfg_retry,
   output logic [31:0]     cfg_rdata,
   input  logic            ld_vld,
   input  logic [CC_W-1:0] ld_val,
   output logic            done_q,
   output logic [15:0]     cmd_q,
   output logic            unlock_q,
   output logic [CC_W-1:0] class_q
);

   localparam logic [15:0] STAT_RO = {10'b0, CAP_66MHZ, CAPS_LIST, 4'b0};

   logic [31:0] rd_mux;
   logic        wr_ok;

   assign wr_ok = cfg_req & cfg_we & done_q;

   always_comb begin
      case (cfg_dw_addr)
         DW_CMD:   rd_mux = {STAT_RO, cmd_q};
         DW_CLASS: rd_mux = {class_q, REV_ID};
         DW_CAP:   rd_mux = {24'b0, CAP_PTR};
         DW_CFG:   rd_mux = {31'b0, unlock_q};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_ack   <= 1'b0;
         cfg_retry <= 1'b0;
         cfg_rdata <= '0;
         done_q    <= 1'b0;
         cmd_q     <= '0;
         unlock_q  <= 1'b0;
         class_q   <= '0;
      end else begin
         cfg_ack   <= cfg_req;
         cfg_retry <= cfg_req & ~done_q;
         cfg_rdata <= (cfg_req && !cfg_we && done_q) ? rd_mux : '0;
         if (ld_vld) begin
            class_q <= ld_val;
            done_q  <= 1'b1;
         end
         if (wr_ok) begin
            case (cfg_dw_addr)
               DW_CMD: begin
                  for (int b = 0; b < 2; b++)
                     if (cfg_be[b])
                        cmd_q[8*b +: 8] <= cfg_wdata[8*b +: 8] & CMD_WMASK[8*b +: 8];
               end
               DW_CLASS: begin
                  if (unlock_q)
                     for (int b = 1; b < 4; b++)
                        if (cfg_be[b])
                           class_q[8*(b-1) +: 8] <= cfg_wdata[8*b +: 8];
               end
               DW_CFG: begin
                  if (cfg_be[0]) unlock_q <= cfg_wdata[0];
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgpl_serr_gate.sv
module cfgpl_serr_gate #(
   parameter bit SERR_REG = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic par_err,
   input  logic serr_en,
   input  logic perr_en,
   output logic serr_o
);

   logic fire;
   assign fire = par_err & perr_en & serr_en;

   if (SERR_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) serr_o <= 1'b0;
         else        serr_o <= fire;
      end
   end else begin : g_comb
      assign serr_o = fire & rst_n;
   end

endmodule

// File: rtl/cfg_preload_ctrl.sv
module cfg_preload_ctrl
   import cfgpl_pkg::*;
#(
   parameter int          ADDR_W    = 20,
   parameter logic [7:0]  REV_ID    = 8'h01,
   parameter logic [7:0]  CAP_PTR   = 8'h60,
   parameter logic [15:0] CMD_WMASK = 16'h0147,
   parameter bit          SERR_REG  = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jumper_sel,
   output logic              nvm_req,
   output logic              nvm_dev,
   output logic [ADDR_W-1:0] nvm_addr,
   input  logic              nvm_ack,
   input  logic [7:0]        nvm_rdata,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_dw_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic              cfg_ack,
   output logic              cfg_retry,
   output logic [31:0]       cfg_rdata,
   input  logic              addr_par_err,
   output logic              serr_o,
   output logic              preload_done
);

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
      $error("cfg_preload_ctrl: ADDR_W must lie in 4..32");
   end
   if (CMD_WMASK[15:9] != 7'b0 || !CMD_WMASK[8] || !CMD_WMASK[6]) begin : g_bad_mask
      $error("cfg_preload_ctrl: CMD_WMASK must keep bits 8 and 6 and nothing above 8");
   end

   logic              ld_vld;
   logic [CC_W-1:0]   ld_val;
   logic [15:0]       cmd_word;
   logic              unlock_bit;
   logic [CC_W-1:0]   class_code;

   cfgpl_probe #(.ADDR_W(ADDR_W)) u_probe (
      .clk        (clk),
      .rst_n      (rst_n),
      .jumper_sel (jumper_sel),
      .nvm_req    (nvm_req),
      .nvm_dev    (nvm_dev),
      .nvm_addr   (nvm_addr),
      .nvm_ack    (nvm_ack),
      .nvm_rdata  (nvm_rdata),
      .ld_vld     (ld_vld),
      .ld_val     (ld_val)
   );

   cfgpl_regs #(
      .REV_ID    (REV_ID),
      .CAP_PTR   (CAP_PTR),
      .CMD_WMASK (CMD_WMASK)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_req     (cfg_req),
      .cfg_we      (cfg_we),
      .cfg_dw_addr (cfg_dw_addr),
      .cfg_be      (cfg_be),
      .cfg_wdata   (cfg_wdata),
      .cfg_ack     (cfg_ack),
      .cfg_retry   (cfg_retry),
      .cfg_rdata   (cfg_rdata),
      .ld_vld      (ld_vld),
      .ld_val      (ld_val),
      .done_q      (preload_done),
      .cmd_q       (cmd_word),
      .unlock_q    (unlock_bit),
      .class_q     (class_code)
   );

   cfgpl_serr_gate #(.SERR_REG(SERR_REG)) u_serr (
      .clk     (clk),
      .rst_n   (rst_n),
      .par_err (addr_par_err),
      .serr_en (cmd_word[8]),
      .perr_en (cmd_word[6]),
      .serr_o  (serr_o)
   );

endmodule

// File: rtl/cfgpl_chk.sv
module cfgpl_chk #(
   parameter int         ADDR_W   = 20,
   parameter logic [7:0] REV_ID   = 8'h01,
   parameter bit         SERR_REG = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              nvm_req,
   input logic              nvm_dev,
   input logic [ADDR_W-1:0] nvm_addr,
   input logic              nvm_ack,
   input logic              cfg_req,
   input logic              cfg_we,
   input logic [5:0]        cfg_dw_addr,
   input logic              cfg_ack,
   input logic              cfg_retry,
   input logic [31:0]       cfg_rdata,
   input logic              addr_par_err,
   input logic              serr_o,
   input logic              preload_done,
   input logic [15:0]       cmd_word,
   input logic              unlock_bit,
   input logic [23:0]       class_code
);

   // R11
   nvm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nvm_req && !nvm_ack |=> nvm_req && $stable(nvm_addr) && $stable(nvm_dev));

   // R1
   retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ack && cfg_retry |-> !$past(preload_done));

   // R1
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preload_done |=> preload_done);

   // R1
   nvm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preload_done |-> !nvm_req);

   // R5
   rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_req && !cfg_we && cfg_dw_addr == 6'h02) && cfg_ack && !cfg_retry
      |-> cfg_rdata[7:0] == REV_ID);

   // R6
   class_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preload_done && !unlock_bit |=> $stable(class_code));

   // R12
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |=> cfg_ack);

   // R12
   no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_req |=> !cfg_ack);

   if (SERR_REG) begin : g_serr
      // R9
      serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         serr_o |-> $past(addr_par_err));

      // R9
      serr_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cmd_word[6] |=> !serr_o);
   end

endmodule

bind cfg_preload_ctrl cfgpl_chk #(
   .ADDR_W   (ADDR_W),
   .REV_ID   (REV_ID),
   .SERR_REG (SERR_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .nvm_req      (nvm_req),
   .nvm_dev      (nvm_dev),
   .nvm_addr     (nvm_addr),
   .nvm_ack      (nvm_ack),
   .cfg_req      (cfg_req),
   .cfg_we       (cfg_we),
   .cfg_dw_addr  (cfg_dw_addr),
   .cfg_ack      (cfg_ack),
   .cfg_retry    (cfg_retry),
   .cfg_rdata    (cfg_rdata),
   .addr_par_err (addr_par_err),
   .serr_o       (serr_o),
   .preload_done (preload_done),
   .cmd_word     (cmd_word),
   .unlock_bit   (unlock_bit),
   .class_code   (class_code)
);

// File: tb/test_cfg_preload_ctrl.sv
`timescale 1ns/1ps
module test_cfg_preload_ctrl;

   localparam int ADDR_W = 20;
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
   localparam int LAT = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              jumper_sel = 1'b0;
   logic              nvm_req, nvm_dev;
   logic [ADDR_W-1:0] nvm_addr;
   logic              nvm_ack = 1'b0;
   logic [7:0]        nvm_rdata = 8'h00;
   logic              cfg_req = 1'b0, cfg_we = 1'b0;
   logic [5:0]        cfg_dw_addr = '0;
   logic [3:0]        cfg_be = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              cfg_ack, cfg_retry;
   logic [31:0]       cfg_rdata;
   logic              addr_par_err = 1'b0;
   logic              serr_o, preload_done;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] ee [8];
   logic [7:0] fl [8];
   logic       fl_touched;
   int         cnt;

   always #10 clk = ~clk;

   cfg_preload_ctrl #(.ADDR_W(ADDR_W)) i_cfg_preload_ctrl (
      .clk(clk), .rst_n(rst_n), .jumper_sel(jumper_sel),
      .nvm_req(nvm_req), .nvm_dev(nvm_dev), .nvm_addr(nvm_addr),
      .nvm_ack(nvm_ack), .nvm_rdata(nvm_rdata),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_retry(cfg_retry), .cfg_rdata(cfg_rdata),
      .addr_par_err(addr_par_err), .serr_o(serr_o), .preload_done(preload_done)
   );

   function automatic logic [7:0] mem_rd(input logic dev, input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] d;
      if (!dev) return (a < 8) ? ee[a[2:0]] : 8'hFF;
      d = TOP - a;
      return (d < 8) ? fl[d[2:0]] : 8'hFF;
   endfunction

   // memory model
   initial begin
      cnt = 0;
      fl_touched = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            nvm_ack = 1'b0; cnt = 0;
         end else if (nvm_ack) begin
            nvm_ack = 1'b0; cnt = 0;
         end else if (nvm_req) begin
            if (nvm_dev) fl_touched = 1'b1;
            if (cnt == LAT) begin
               nvm_ack   = 1'b1;
               nvm_rdata = mem_rd(nvm_dev, nvm_addr);
            end else cnt++;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic set_ee(input bit valid, input logic [23:0] cc);
      ee[0] = 8'hAA; ee[1] = 8'h55; ee[2] = 8'hAA; ee[3] = valid ? 8'h55 : 8'h54;
      ee[4] = cc[7:0]; ee[5] = cc[15:8]; ee[6] = cc[23:16]; ee[7] = 8'h00;
   endtask

   task automatic set_fl(input bit valid, input logic [23:0] cc);
      fl[0] = 8'hAA; fl[1] = 8'h55; fl[2] = 8'h00; fl[3] = valid ? 8'h55 : 8'hAA;
      fl[4] = 8'h00; fl[5] = cc[23:16]; fl[6] = cc[15:8]; fl[7] = cc[7:0];
   endtask

   task automatic do_reset(input bit jp);
      @(negedge clk);
      rst_n = 1'b0; jumper_sel = jp; fl_touched = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_done();
      int k;
      k = 0;
      while (!preload_done && k < 2000) begin
         @(negedge clk); k++;
      end
   endtask

   task automatic xfer(input bit we, input logic [5:0] dw, input logic [31:0] d,
                       input logic [3:0] be, output logic [31:0] rd, output logic rt,
                       output logic ak);
      @(negedge clk);
      cfg_req = 1'b1; cfg_we = we; cfg_dw_addr = dw; cfg_wdata = d; cfg_be = be;
      @(negedge clk);
      cfg_req = 1'b0; cfg_we = 1'b0;
      rd = cfg_rdata; rt = cfg_retry; ak = cfg_ack;
   endtask

   task automatic rd_chk(input string tag, input logic [5:0] dw, input logic [31:0] exp);
      logic [31:0] rd; logic rt, ak;
      xfer(1'b0, dw, '0, 4'h0, rd, rt, ak);
      check({tag, " ack"}, {31'b0, ak & ~rt}, 32'd1);
      check(tag, rd, exp);
   endtask

   task automatic wr(input logic [5:0] dw, input logic [31:0] d, input logic [3:0] be);
      logic [31:0] rd; logic rt, ak;
      xfer(1'b1, dw, d, be, rd, rt, ak);
   endtask

   task automatic t_retry_window();
      logic [31:0] rd; logic rt, ak;
      set_ee(1'b1, 24'h123456); set_fl(1'b0, 24'h0);
      do_reset(1'b0);
      check("R1 done low after reset", {31'b0, preload_done}, 32'd0);
      xfer(1'b1, 6'h01, 32'hFFFF_FFFF, 4'hF, rd, rt, ak);
      check("R1 write retried", {30'b0, ak, rt}, 32'd3);
      xfer(1'b0, 6'h02, '0, 4'h0, rd, rt, ak);
      check("R1 read retried", {30'b0, ak, rt}, 32'd3);
      wait_done();
      check("R1 done raised", {31'b0, preload_done}, 32'd1);
      check("R1 nvm idle after done", {31'b0, nvm_req}, 32'd0);
      rd_chk("R1 early write dropped", 6'h01, 32'h0010_0000);
   endtask

   task automatic t_ee_load();
      set_ee(1'b1, 24'h123456); set_fl(1'b1, 24'h777777);
      do_reset(1'b1);
      wait_done();
      rd_chk("R2 serial class code", 6'h02, 32'h1234_5601);
      check("R2 parallel untouched", {31'b0, fl_touched}, 32'd0);
   endtask

   task automatic t_fl_load();
      set_ee(1'b0, 24'h999999); set_fl(1'b1, 24'hABCDEF);
      do_reset(1'b0);
      wait_done();
      rd_chk("R3 parallel class code", 6'h02, 32'hABCD_EF01);
   endtask

   task automatic t_defaults();
      set_ee(1'b0, 24'h0); set_fl(1'b0, 24'h5A5A5A);
      do_reset(1'b0);
      wait_done();
      rd_chk("R4 default jumper0", 6'h02, 32'h0104_0001);
      do_reset(1'b1);
      wait_done();
      rd_chk("R4 default jumper1", 6'h02, 32'h0101_8501);
      check("R3 parallel probed on fallback", {31'b0, fl_touched}, 32'd1);
   endtask

   task automatic t_unlock();
      set_ee(1'b0, 24'h0); set_fl(1'b0, 24'h0);
      do_reset(1'b1);
      wait_done();
      rd_chk("R7 unlock resets 0", 6'h10, 32'h0);
      wr(6'h02, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R6 locked write ignored", 6'h02, 32'h0101_8501);
      wr(6'h10, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R7 unlock set", 6'h10, 32'h1);
      wr(6'h02, 32'hA1B2_C3D4, 4'hF);
      rd_chk("R6 unlocked write", 6'h02, 32'hA1B2_C301);
      wr(6'h02, 32'h0000_7700, 4'h2);
      rd_chk("R6 byte enable", 6'h02, 32'hA1B2_7701);
      wr(6'h10, 32'h0, 4'h1);
      wr(6'h02, 32'h1111_1111, 4'hF);
      rd_chk("R6 relocked", 6'h02, 32'hA1B2_7701);
   endtask

   task automatic t_cmd_and_misc();
      wr(6'h01, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R8 command mask", 6'h01, 32'h0010_0147);
      wr(6'h01, 32'h0000_0000, 4'h1);
      rd_chk("R8 low byte only", 6'h01, 32'h0010_0100);
      rd_chk("R10 capability pointer", 6'h0D, 32'h0000_0060);
      rd_chk("R10 unmapped", 6'h00, 32'h0);
   endtask

   task automatic pulse_perr(input string tag, input logic exp);
      @(negedge clk);
      addr_par_err = 1'b1;
      @(negedge clk);
      addr_par_err = 1'b0;
      check(tag, {31'b0, serr_o}, {31'b0, exp});
      @(negedge clk);
      check({tag, " drop"}, {31'b0, serr_o}, 32'd0);
   endtask

   task automatic t_serr();
      wr(6'h01, 32'h0000_0140, 4'h3);
      pulse_perr("R9 both enables", 1'b1);
      wr(6'h01, 32'h0000_0100, 4'h3);
      pulse_perr("R9 parity response off", 1'b0);
      wr(6'h01, 32'h0000_0040, 4'h3);
      pulse_perr("R9 serr enable off", 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_retry_window();
      t_ee_load();
      t_fl_load();
      t_defaults();
      t_unlock();
      t_cmd_and_misc();
      t_serr();
      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule